// File: doc/BRIEF.md
# Host Register Interface for a Serial Bus Master

This block is the register front end of a two-wire serial bus master. A microprocessor reaches it over a plain 8-bit bus. The bus has an active-low select, a 3-bit register address, a read/write select, separate write and read data lanes, and an active-low interrupt line. The block holds the values that set up a transfer:
- the target address with its direction bit,
- the transfer length in bytes,
- the outgoing data byte,
- the command settings (speed mode and the two interrupt enables).

It presents these values as plain levels to the transfer engine next to it. It turns the start and stop-request command bits into single-cycle pulses.

The engine reports back in two ways. Status levels (busy, error, abort done, arbitration lost, done) pass straight through to the status register. Two one-cycle events raise the buffer flags: "outgoing byte taken" and "incoming byte valid". A host write to the data register clears the outgoing-buffer-empty flag. A host read of the data register clears the incoming-buffer-full flag. An enabled flag-set event latches a pending interrupt. Only an acknowledge write removes it. Under this scheme the processor can run either interrupt-driven or by polling the status register.

The host bus has no wait signalling here. A register access takes effect on the third rising clock edge of an unbroken low select, and address and data must be held for that whole time.

Top module: `hreg_if`

## Requirements
- R1: Register addresses are 000 data, 001 target, 100 command (write) / status (read), 101 length, 110 interrupt acknowledge. A target write drives bits 7..1 onto `tgt_addr` and bit 0 onto `tgt_read`, and reads back unchanged. A length write drives `xfer_len` and reads back. A data write drives `tx_byte`.
- R2: A host access takes effect only on the third rising edge of a continuous low `cs_n`. A select held for two edges or fewer has no effect. A select held longer takes effect exactly once.
- R3: A command write loads bit 3 as `fast_mode`, bit 1 as the transmit interrupt enable and bit 0 as the receive interrupt enable.
- R4: A status read returns bit 7 busy, 6 error, 5 abort done, 4 arbitration lost, 3 done, 2 zero, 1 transmit buffer empty, 0 receive buffer full.
- R5: `eng_tx_taken` sets transmit-empty. A host write to the data register clears it.
- R6: `eng_rx_valid` stores `eng_rx_byte` and sets receive-full. A host read of the data register returns the stored byte and clears receive-full.
- R7: An engine event whose interrupt enable is on drives `irq_n` low in the following cycle. `irq_n` stays low, even after the flag is cleared, until it is acknowledged. An event whose enable is off does not assert `irq_n`.
- R8: A write to the acknowledge register with bit 0 set releases `irq_n`. The same write with bit 0 clear leaves it low.
- R9: A command write with bit 7 set gives exactly one `start_pulse` cycle. Bit 6 set gives exactly one `abort_pulse` cycle. Without these bits neither pulse occurs.
- R10: Reads of addresses 010, 011, 110 and 111 return zero. Writes to 010, 011 and 111 change no register.
- R11: After reset, `irq_n` is high, both flags are clear, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Host select, active low |
| addr | input | 3 | Host register address |
| rd_wr | input | 1 | 1 = host read, 0 = host write |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, zero unless a read is selected |
| irq_n | output | 1 | Interrupt request, active low |
| eng_busy | input | 1 | Engine: bus busy |
| eng_err | input | 1 | Engine: transfer error |
| eng_abort_ack | input | 1 | Engine: abort completed |
| eng_lost_arb | input | 1 | Engine: arbitration lost |
| eng_done | input | 1 | Engine: transfer done |
| eng_tx_taken | input | 1 | Engine: outgoing byte consumed (one cycle) |
| eng_rx_valid | input | 1 | Engine: incoming byte valid (one cycle) |
| eng_rx_byte | input | 8 | Engine: incoming byte |
| start_pulse | output | 1 | One-cycle transfer start |
| abort_pulse | output | 1 | One-cycle abort request |
| fast_mode | output | 1 | Speed mode select |
| tgt_addr | output | 7 | Target device address |
| tgt_read | output | 1 | Target direction, 1 = read |
| xfer_len | output | 8 | Transfer length in bytes |
| tx_byte | output | 8 | Outgoing data byte |

## Verification
The bench builds the block with the default strobe count of three edges. With that count, two-edge selects and five-edge selects can both be generated, so the bench shows both a dropped access and an over-held access that takes effect exactly once. Each flag is driven from both sides in turn: an engine event sets it and a host data access clears it. Each interrupt enable is tested on and off. The pending interrupt is shown to outlive the flag that raised it until a proper acknowledge.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        RA_DATA = 3'b000,
        RA_TGT  = 3'b001,
        RA_RSV2 = 3'b010,
        RA_RSV3 = 3'b011,
        RA_CMD  = 3'b100,
        RA_LEN  = 3'b101,
        RA_ACK  = 3'b110,
        RA_RSV7 = 3'b111
    } reg_addr_e;

    // command register bit positions (host-visible)
    localparam int CB_GO    = 7;
    localparam int CB_ABORT = 6;
    localparam int CB_FAST  = 3;
    localparam int CB_TXIE  = 1;
    localparam int CB_RXIE  = 0;
    localparam int ACK_BIT  = 0;

    typedef struct packed {
        logic busy;
        logic err;
        logic abort_ack;
        logic lost_arb;
        logic done;
    } eng_stat_t;

    typedef struct packed {
        logic fast;
        logic tx_ie;
        logic rx_ie;
    } cmd_cfg_t;

    typedef struct packed {
        logic [DW-2:0] addr;
        logic          rd;
    } target_t;

    typedef struct packed {
        logic          wr;
        logic          rd;
        reg_addr_e     addr;
        logic [DW-1:0] data;
    } host_op_t;

    function automatic logic [DW-1:0] pack_status(eng_stat_t s, logic tx_e, logic rx_f);
        return {s.busy, s.err, s.abort_ack, s.lost_arb, s.done, 1'b0, tx_e, rx_f};
    endfunction

endpackage

// File: rtl/hreg_strobe.sv
module hreg_strobe
    import hreg_pkg::*;
#(
    parameter int STROBE_CYC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output host_op_t      op
);
    localparam int CW = $clog2(STROBE_CYC + 1);
    localparam logic [CW-1:0] FIRE_AT = CW'(STROBE_CYC - 1);
    localparam logic [CW-1:0] SAT_AT  = CW'(STROBE_CYC);

    logic [CW-1:0] hold_q;
    logic          fire;

    // count edges of an unbroken select, saturating so a long hold fires once
    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            hold_q <= '0;
        end else if (hold_q != SAT_AT) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    assign fire = !cs_n && (hold_q == FIRE_AT);

    always_comb begin
        op.wr   = fire && !rd_wr;
        op.rd   = fire && rd_wr;
        op.addr = reg_addr_e'(addr);
        op.data = wdata;
    end
endmodule

// File: rtl/hreg_regs.sv
module hreg_regs
    import hreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  reg_addr_e     wr_addr,
    input  logic [DW-1:0] wr_data,
    output target_t       tgt,
    output logic [DW-1:0] len,
    output logic [DW-1:0] tx_hold,
    output cmd_cfg_t      cfg,
    output logic          go_pulse,
    output logic          abort_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt         <= '0;
            len         <= '0;
            tx_hold     <= '0;
            cfg         <= '0;
            go_pulse    <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            go_pulse    <= 1'b0;
            abort_pulse <= 1'b0;
            if (wr_stb) begin
                case (wr_addr)
                    RA_DATA: tx_hold <= wr_data;
                    RA_TGT:  tgt     <= target_t'(wr_data);
                    RA_LEN:  len     <= wr_data;
                    RA_CMD: begin
                        cfg.fast    <= wr_data[CB_FAST];
                        cfg.tx_ie   <= wr_data[CB_TXIE];
                        cfg.rx_ie   <= wr_data[CB_RXIE];
                        go_pulse    <= wr_data[CB_GO];
                        abort_pulse <= wr_data[CB_ABORT];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/hreg_flags.sv
module hreg_flags
    import hreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic          ack_wr,
    input  cmd_cfg_t      cfg,
    input  logic          tx_taken,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          tx_empty,
    output logic          rx_full,
    output logic [DW-1:0] rx_hold,
    output logic          irq_pend
);
    logic raise;

    assign raise = (tx_taken && cfg.tx_ie) || (rx_valid && cfg.rx_ie);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_empty <= 1'b0;
            rx_full  <= 1'b0;
            rx_hold  <= '0;
            irq_pend <= 1'b0;
        end else begin
            // engine events take precedence over host clears
            if (tx_taken)     tx_empty <= 1'b1;
            else if (data_wr) tx_empty <= 1'b0;

            if (rx_valid) begin
                rx_full <= 1'b1;
                rx_hold <= rx_byte;
            end else if (data_rd) begin
                rx_full <= 1'b0;
            end

            if (raise)       irq_pend <= 1'b1;
            else if (ack_wr) irq_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/hreg_if.sv
module hreg_if
    import hreg_pkg::*;
#(
    parameter int STROBE_CYC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic [2:0]    addr,
    input  logic          rd_wr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          irq_n,
    input  logic          eng_busy,
    input  logic          eng_err,
    input  logic          eng_abort_ack,
    input  logic          eng_lost_arb,
    input  logic          eng_done,
    input  logic          eng_tx_taken,
    input  logic          eng_rx_valid,
    input  logic [7:0]    eng_rx_byte,
    output logic          start_pulse,
    output logic          abort_pulse,
    output logic          fast_mode,
    output logic [6:0]    tgt_addr,
    output logic          tgt_read,
    output logic [7:0]    xfer_len,
    output logic [7:0]    tx_byte
);
    host_op_t      host_op;
    target_t       tgt;
    cmd_cfg_t      cfg;
    eng_stat_t     stat;
    logic          tx_empty;
    logic          rx_full;
    logic [DW-1:0] rx_hold;
    logic          irq_pend;
    logic          data_wr;
    logic          data_rd;
    logic          ack_wr;

    hreg_strobe #(.STROBE_CYC(STROBE_CYC)) u_strobe (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .rd_wr (rd_wr),
        .addr  (addr),
        .wdata (wdata),
        .op    (host_op)
    );

    hreg_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (host_op.wr),
        .wr_addr     (host_op.addr),
        .wr_data     (host_op.data),
        .tgt         (tgt),
        .len         (xfer_len),
        .tx_hold     (tx_byte),
        .cfg         (cfg),
        .go_pulse    (start_pulse),
        .abort_pulse (abort_pulse)
    );

    assign data_wr = host_op.wr && (host_op.addr == RA_DATA);
    assign data_rd = host_op.rd && (host_op.addr == RA_DATA);
    assign ack_wr  = host_op.wr && (host_op.addr == RA_ACK) && host_op.data[ACK_BIT];

    hreg_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .ack_wr   (ack_wr),
        .cfg      (cfg),
        .tx_taken (eng_tx_taken),
        .rx_valid (eng_rx_valid),
        .rx_byte  (eng_rx_byte),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .rx_hold  (rx_hold),
        .irq_pend (irq_pend)
    );

    always_comb begin
        stat.busy      = eng_busy;
        stat.err       = eng_err;
        stat.abort_ack = eng_abort_ack;
        stat.lost_arb  = eng_lost_arb;
        stat.done      = eng_done;
    end

    always_comb begin
        rdata = '0;
        if (!cs_n && rd_wr) begin
            case (reg_addr_e'(addr))
                RA_DATA: rdata = rx_hold;
                RA_TGT:  rdata = tgt;
                RA_CMD:  rdata = pack_status(stat, tx_empty, rx_full);
                RA_LEN:  rdata = xfer_len;
                default: rdata = '0;
            endcase
        end
    end

    assign irq_n     = !irq_pend;
    assign fast_mode = cfg.fast;
    assign tgt_addr  = tgt.addr;
    assign tgt_read  = tgt.rd;
endmodule

// File: rtl/hreg_chk.sv
module hreg_chk
    import hreg_pkg::*;
#(
    parameter int STROBE_CYC = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       irq_n,
    input logic       start_pulse,
    input logic       abort_pulse,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic [2:0] op_addr,
    input logic       op_bit0,
    input logic       tx_taken,
    input logic       rx_valid,
    input logic       tx_ie,
    input logic       rx_ie,
    input logic       rx_full,
    input logic [7:0] tgt_word
);
    logic raise_ev;
    assign raise_ev = (tx_taken && tx_ie) || (rx_valid && rx_ie);

    a_r9_go_single: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    a_r9_abort_single: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);

    a_r2_no_early_write: assert property (@(posedge clk) disable iff (rst)
        ((STROBE_CYC >= 3) && $fell(cs_n)) |=> $stable(tgt_word));

    a_r7_irq_raise: assert property (@(posedge clk) disable iff (rst)
        raise_ev |=> !irq_n);

    a_r7_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(raise_ev));

    a_r8_ack_releases: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && op_addr == RA_ACK && op_bit0 && !raise_ev) |=> irq_n);

    a_r6_read_clears_full: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && op_addr == RA_DATA && !rx_valid) |=> !rx_full);
endmodule

bind hreg_if hreg_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .irq_n       (irq_n),
    .start_pulse (start_pulse),
    .abort_pulse (abort_pulse),
    .wr_stb      (host_op.wr),
    .rd_stb      (host_op.rd),
    .op_addr     (host_op.addr),
    .op_bit0     (host_op.data[0]),
    .tx_taken    (eng_tx_taken),
    .rx_valid    (eng_rx_valid),
    .tx_ie       (cfg.tx_ie),
    .rx_ie       (cfg.rx_ie),
    .rx_full     (rx_full),
    .tgt_word    ({tgt_addr, tgt_read})
);

// File: tb/tb_hreg_if.sv
module tb_hreg_if;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic [2:0] addr = '0;
    logic       rd_wr = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;
    logic       eng_busy = 0, eng_err = 0, eng_abort_ack = 0, eng_lost_arb = 0, eng_done = 0;
    logic       eng_tx_taken = 0, eng_rx_valid = 0;
    logic [7:0] eng_rx_byte = '0;
    logic       start_pulse, abort_pulse, fast_mode, tgt_read;
    logic [6:0] tgt_addr;
    logic [7:0] xfer_len, tx_byte;

    hreg_if dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rd_wr(rd_wr),
        .wdata(wdata), .rdata(rdata), .irq_n(irq_n),
        .eng_busy(eng_busy), .eng_err(eng_err), .eng_abort_ack(eng_abort_ack),
        .eng_lost_arb(eng_lost_arb), .eng_done(eng_done),
        .eng_tx_taken(eng_tx_taken), .eng_rx_valid(eng_rx_valid),
        .eng_rx_byte(eng_rx_byte), .start_pulse(start_pulse),
        .abort_pulse(abort_pulse), .fast_mode(fast_mode), .tgt_addr(tgt_addr),
        .tgt_read(tgt_read), .xfer_len(xfer_len), .tx_byte(tx_byte)
    );

    int n_chk = 0;
    int n_bad = 0;
    int go_cnt = 0;
    int ab_cnt = 0;
    bit finished = 0;

    always @(posedge clk) begin
        if (start_pulse) go_cnt++;
        if (abort_pulse) ab_cnt++;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [2:0] a, logic [7:0] d, int hold = 3);
        @(negedge clk);
        cs_n = 0; addr = a; wdata = d; rd_wr = 0;
        repeat (hold) @(negedge clk);
        cs_n = 1; rd_wr = 1;
    endtask

    task automatic host_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 0; addr = a; rd_wr = 1;
        repeat (2) @(negedge clk);
        d = rdata;
        @(negedge clk);
        cs_n = 1;
    endtask

    task automatic pulse_tx();
        @(negedge clk); eng_tx_taken = 1;
        @(negedge clk); eng_tx_taken = 0;
    endtask

    task automatic pulse_rx(logic [7:0] b);
        @(negedge clk); eng_rx_valid = 1; eng_rx_byte = b;
        @(negedge clk); eng_rx_valid = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R11 irq_n", irq_n, 1);
        host_read(3'b100, v); chk("R11 status", v, 8'h00);
        host_read(3'b001, v); chk("R11 target", v, 8'h00);
        host_read(3'b000, v); chk("R11 data", v, 8'h00);
        chk("R11 idle rdata", rdata, 8'h00);
    endtask

    task automatic t_map();
        logic [7:0] v;
        host_write(3'b001, 8'hA5);
        chk("R1 tgt_addr", tgt_addr, 7'h52);
        chk("R1 tgt_read", tgt_read, 1);
        host_read(3'b001, v); chk("R1 target readback", v, 8'hA5);
        host_write(3'b101, 8'h3C);
        chk("R1 xfer_len", xfer_len, 8'h3C);
        host_read(3'b101, v); chk("R1 length readback", v, 8'h3C);
        host_write(3'b000, 8'h7E);
        chk("R1 tx_byte", tx_byte, 8'h7E);
    endtask

    task automatic t_strobe();
        logic [7:0] v;
        int g0;
        host_write(3'b001, 8'h11, 2);
        host_read(3'b001, v); chk("R2 short select ignored", v, 8'hA5);
        g0 = go_cnt;
        host_write(3'b100, 8'h80, 5);
        repeat (2) @(negedge clk);
        chk("R2 long select one start", go_cnt - g0, 1);
        host_write(3'b001, 8'h22, 5);
        host_read(3'b001, v); chk("R2 long select write", v, 8'h22);
    endtask

    task automatic t_cmd();
        int g0, a0;
        g0 = go_cnt; a0 = ab_cnt;
        host_write(3'b100, 8'h0A);
        repeat (2) @(negedge clk);
        chk("R3 fast_mode set", fast_mode, 1);
        chk("R9 no start without bit 7", go_cnt - g0, 0);
        host_write(3'b100, 8'h80);
        repeat (2) @(negedge clk);
        chk("R9 one start pulse", go_cnt - g0, 1);
        chk("R3 fast_mode cleared", fast_mode, 0);
        chk("R9 no abort without bit 6", ab_cnt - a0, 0);
        host_write(3'b100, 8'h40);
        repeat (2) @(negedge clk);
        chk("R9 one abort pulse", ab_cnt - a0, 1);
        chk("R9 abort gives no start", go_cnt - g0, 1);
    endtask

    task automatic t_status();
        logic [7:0] v;
        eng_busy = 1; eng_lost_arb = 1;
        host_read(3'b100, v); chk("R4 busy+lost_arb", v, 8'h90);
        eng_busy = 0; eng_lost_arb = 0;
        eng_err = 1; eng_abort_ack = 1; eng_done = 1;
        host_read(3'b100, v); chk("R4 err+abort+done", v, 8'h68);
        eng_err = 0; eng_abort_ack = 0; eng_done = 0;
    endtask

    task automatic t_tx();
        logic [7:0] v;
        pulse_tx();
        host_read(3'b100, v); chk("R5 tx empty set", v, 8'h02);
        host_write(3'b000, 8'h55);
        host_read(3'b100, v); chk("R5 tx empty cleared", v, 8'h00);
        chk("R5 tx_byte", tx_byte, 8'h55);
    endtask

    task automatic t_rx();
        logic [7:0] v;
        pulse_rx(8'hC3);
        host_read(3'b100, v); chk("R6 rx full set", v, 8'h01);
        host_read(3'b000, v); chk("R6 rx data", v, 8'hC3);
        host_read(3'b100, v); chk("R6 rx full cleared", v, 8'h00);
    endtask

    task automatic t_irq();
        host_write(3'b100, 8'h00);
        pulse_tx();
        chk("R7 disabled event no irq", irq_n, 1);
        host_write(3'b000, 8'h01);
        host_write(3'b100, 8'h02);
        pulse_tx();
        chk("R7 tx irq asserted", irq_n, 0);
        host_write(3'b000, 8'h02);
        chk("R7 irq held after flag clear", irq_n, 0);
        host_write(3'b110, 8'hFE);
        chk("R8 ack without bit0 keeps irq", irq_n, 0);
        host_write(3'b110, 8'h01);
        chk("R8 ack releases irq", irq_n, 1);
        pulse_rx(8'h3D);
        chk("R7 rx event with tx enable only", irq_n, 1);
        host_write(3'b100, 8'h01);
        pulse_rx(8'h4E);
        chk("R7 rx irq asserted", irq_n, 0);
        host_write(3'b110, 8'h01);
        chk("R8 rx ack releases irq", irq_n, 1);
        host_write(3'b100, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        host_write(3'b010, 8'hFF);
        host_write(3'b011, 8'hFF);
        host_write(3'b111, 8'hFF);
        host_read(3'b001, v); chk("R10 target untouched", v, 8'h22);
        host_read(3'b101, v); chk("R10 length untouched", v, 8'h3C);
        host_read(3'b010, v); chk("R10 read 010", v, 0);
        host_read(3'b011, v); chk("R10 read 011", v, 0);
        host_read(3'b110, v); chk("R10 read 110", v, 0);
        host_read(3'b111, v); chk("R10 read 111", v, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_map();
        t_strobe();
        t_cmd();
        t_status();
        t_tx();
        t_rx();
        t_irq();
        t_reserved();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule